// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block is a small real-time clock peripheral on a simple 32-bit register bus. A seconds counter moves forward by one on every cycle in which an externally generated one-second strobe is high. Software can overwrite the counter at any time and can program a compare value. When an event (a tick, a counter load or a compare write) leaves the counter equal to the compare value, a sticky raw status bit is set. A one-bit enable gates that status onto a registered interrupt line.

Internally the counter is a free-running base plus an offset. A load does not touch the base. It rewrites the offset so that the sum equals the written value. Writes that the block cannot accept are dropped: writes to read-only words, to words outside the map, and to addresses that are not word aligned. Each dropped write produces a one-cycle error pulse. Reads are registered and return data one cycle after the request.

Top module: `sec_rtc`

## Requirements
- R1: Synchronous reset clears the counter, compare value, enable bit, raw status, `irq`, `bad_wr` and `rdata` to zero. Reset itself never sets raw status, even though the counter and compare value are then equal.
- R2: On each clock edge where `tick` is high and no load is written, the counter (read at byte offset 0x00) rises by one. It wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x08 makes the counter equal to `wdata` at that edge. This holds even if `tick` is high in the same cycle.
- R4: A write to offset 0x04 stores the compare value, which reads back at 0x04. Raw status is set at that edge if the counter equals the new value, including when the value written is the one already stored.
- R5: Raw status (bit 0 of offset 0x14) is set at the edge where a tick or a load makes the counter equal the compare value. It then stays set until cleared.
- R6: A write to offset 0x10 keeps only `wdata[0]` as the interrupt enable. A read of 0x10 returns that bit in bit 0 and zeros above it.
- R7: Any write to offset 0x1C clears raw status, whatever the data. If a set event falls in the same cycle, the set wins.
- R8: `irq` equals raw status AND the enable bit, and it changes at the same edge as either of them. Offset 0x18 reads the same value in bit 0.
- R9: Writes to offset 0x0C change nothing. Reads of 0x0C always return 0x00000001.
- R10: A write to 0x00, 0x14 or 0x18, to any offset of 0x20 or above, or to an address whose two low bits are not zero changes no state. It raises `bad_wr` for exactly the one cycle after the write. Writes to valid writable offsets leave `bad_wr` low.
- R11: `rdata` is updated one cycle after a cycle with `rd_en` high, with the register values held before that edge. Unmapped or unaligned offsets read as 0. `rdata` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second enable strobe, one cycle wide |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Masked interrupt, registered |
| bad_wr | output | 1 | One-cycle pulse after a rejected write |

## Verification
Two functions can fall on the same edge: a set event and a write to the clear register, and a counter load and a seconds tick. The bench provokes each pair by driving `tick` high in the same cycle as the clear write or the load write. The collision is judged at the ports. After tick plus clear, `irq` must read 1 and raw status must read 1, because the set wins. After tick plus load, the counter must read the written value and not that value plus one.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  // word index inside the 32-byte register window
  typedef enum logic [2:0] {
    RI_DATA  = 3'd0,
    RI_MATCH = 3'd1,
    RI_LOAD  = 3'd2,
    RI_CTRL  = 3'd3,
    RI_MASK  = 3'd4,
    RI_RAW   = 3'd5,
    RI_MIS   = 3'd6,
    RI_CLR   = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic load;
    logic match;
    logic mask;
    logic clr;
    logic bad;
  } wr_stb_t;
endpackage

// File: rtl/sec_rtc_decode.sv
module sec_rtc_decode
  import sec_rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_idx_e          idx,
  output wr_stb_t           stb
);
  localparam int HI_W = ADDR_W - 5;

  logic [HI_W-1:0] hi_bits;
  assign hi_bits = addr[ADDR_W-1:5];
  assign hit     = (hi_bits == '0) && (addr[1:0] == 2'b00);
  assign idx     = reg_idx_e'(addr[4:2]);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      if (!hit) begin
        stb.bad = 1'b1;
      end else begin
        unique case (idx)
          RI_LOAD:  stb.load  = 1'b1;
          RI_MATCH: stb.match = 1'b1;
          RI_MASK:  stb.mask  = 1'b1;
          RI_CLR:   stb.clr   = 1'b1;
          RI_CTRL:  stb.bad   = 1'b0;
          default:  stb.bad   = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] count_nxt,
  output logic              evt
);
  logic [DATA_W-1:0] base_q, offs_q;
  logic [DATA_W-1:0] base_nxt, offs_nxt;

  assign base_nxt  = base_q + DATA_W'(tick);
  assign offs_nxt  = load ? (load_val - base_nxt) : offs_q;
  assign count_nxt = base_nxt + offs_nxt;
  assign count     = base_q + offs_q;
  assign evt       = tick | load;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      offs_q <= '0;
    end else begin
      base_q <= base_nxt;
      offs_q <= offs_nxt;
    end
  end
endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_evt,
  input  logic [DATA_W-1:0] count_nxt,
  input  logic              match_we,
  input  logic              mask_we,
  input  logic              clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] match_q,
  output logic              raw_q,
  output logic              mask_q,
  output logic              irq
);
  logic [DATA_W-1:0] match_nxt;
  logic              hit, raw_nxt, mask_nxt;

  assign match_nxt = match_we ? wdata : match_q;
  assign hit       = (cnt_evt | match_we) && (count_nxt == match_nxt);
  assign raw_nxt   = hit | (raw_q & ~clr);
  assign mask_nxt  = mask_we ? wdata[0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      match_q <= match_nxt;
      raw_q   <= raw_nxt;
      mask_q  <= mask_nxt;
      irq     <= raw_nxt & mask_nxt;
    end
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              bad_wr
);
  localparam logic [DATA_W-1:0] CTRL_VAL = DATA_W'(1);

  logic              hit, evt, raw_q, mask_q;
  reg_idx_e          idx;
  wr_stb_t           stb;
  logic [DATA_W-1:0] cnt, cnt_nxt, match_q, rd_mux;

  sec_rtc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .addr(addr), .hit(hit), .idx(idx), .stb(stb)
  );

  sec_rtc_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(stb.load), .load_val(wdata),
    .count(cnt), .count_nxt(cnt_nxt), .evt(evt)
  );

  sec_rtc_alarm #(.DATA_W(DATA_W)) u_alm (
    .clk(clk), .rst(rst), .cnt_evt(evt), .count_nxt(cnt_nxt),
    .match_we(stb.match), .mask_we(stb.mask), .clr(stb.clr), .wdata(wdata),
    .match_q(match_q), .raw_q(raw_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (idx)
        RI_DATA:  rd_mux = cnt;
        RI_MATCH: rd_mux = match_q;
        RI_CTRL:  rd_mux = CTRL_VAL;
        RI_MASK:  rd_mux = DATA_W'(mask_q);
        RI_RAW:   rd_mux = DATA_W'(raw_q);
        RI_MIS:   rd_mux = DATA_W'(raw_q & mask_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      bad_wr <= 1'b0;
    end else begin
      bad_wr <= stb.bad;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              bad_wr,
  input logic [DATA_W-1:0] count,
  input logic              raw,
  input logic              mask
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h1C);

  // R3: a load write sets the counter at the next edge
  a_r3_load_sets_count: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_LOAD) |=> (count == $past(wdata)));

  // R2: a tick without a load advances the counter by one
  a_r2_tick_advances: assert property (@(posedge clk) disable iff (rst)
    (tick && !(wr_en && addr == A_LOAD)) |=> (count == $past(count) + 1'b1));

  // R6: only bit 0 of a mask write is kept
  a_r6_mask_bit0: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_MASK) |=> (mask == $past(wdata[0])));

  // R7: a clear without a same-cycle event leaves raw status low
  a_r7_clear_drops_raw: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR && !tick) |=> !raw);

  // R8: the interrupt line tracks raw status gated by the enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq == (raw & mask));

  // R10: a write to the read-only data word is flagged
  a_r10_ro_flagged: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA) |=> bad_wr);
endmodule

bind sec_rtc sec_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .bad_wr(bad_wr), .count(cnt),
  .raw(raw_q), .mask(mask_q)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [3:0] OP_W = 4'd0, OP_R = 4'd1, OP_T = 4'd2;
  localparam int NV = 31;

  // {op, req, addr, data, expected read}
  localparam logic [79:0] VEC [NV] = '{
    {OP_R, 4'd1,  8'h00, 32'h0,        32'h0},        // R1 counter zero
    {OP_R, 4'd1,  8'h04, 32'h0,        32'h0},        // R1 match zero
    {OP_R, 4'd1,  8'h14, 32'h0,        32'h0},        // R1 no status from reset
    {OP_T, 4'd2,  8'h00, 32'h0,        32'h0},
    {OP_T, 4'd2,  8'h00, 32'h0,        32'h0},
    {OP_T, 4'd2,  8'h00, 32'h0,        32'h0},
    {OP_R, 4'd2,  8'h00, 32'h0,        32'h3},        // R2 three ticks
    {OP_W, 4'd3,  8'h08, 32'h1000,     32'h0},
    {OP_R, 4'd3,  8'h00, 32'h0,        32'h1000},     // R3 load
    {OP_T, 4'd2,  8'h00, 32'h0,        32'h0},
    {OP_R, 4'd2,  8'h00, 32'h0,        32'h1001},     // R2 after load
    {OP_W, 4'd4,  8'h04, 32'h1003,     32'h0},
    {OP_R, 4'd4,  8'h04, 32'h0,        32'h1003},     // R4 readback
    {OP_T, 4'd5,  8'h00, 32'h0,        32'h0},
    {OP_R, 4'd5,  8'h14, 32'h0,        32'h0},        // R5 not yet equal
    {OP_T, 4'd5,  8'h00, 32'h0,        32'h0},
    {OP_R, 4'd5,  8'h14, 32'h0,        32'h1},        // R5 set by tick
    {OP_R, 4'd8,  8'h18, 32'h0,        32'h0},        // R8 masked off
    {OP_W, 4'd6,  8'h10, 32'hFFFFFFFF, 32'h0},
    {OP_R, 4'd6,  8'h10, 32'h0,        32'h1},        // R6 bit 0 only
    {OP_R, 4'd8,  8'h18, 32'h0,        32'h1},        // R8 masked on
    {OP_W, 4'd7,  8'h1C, 32'h0,        32'h0},
    {OP_R, 4'd7,  8'h14, 32'h0,        32'h0},        // R7 zero data clears
    {OP_W, 4'd4,  8'h04, 32'h1003,     32'h0},
    {OP_R, 4'd4,  8'h14, 32'h0,        32'h1},        // R4 re-arm same value
    {OP_W, 4'd9,  8'h0C, 32'h1234,     32'h0},
    {OP_R, 4'd9,  8'h0C, 32'h0,        32'h1},        // R9 control constant
    {OP_W, 4'd10, 8'h00, 32'h55,       32'h0},
    {OP_R, 4'd10, 8'h00, 32'h0,        32'h1003},     // R10 data write dropped
    {OP_R, 4'd11, 8'h24, 32'h0,        32'h0},        // R11 unmapped reads 0
    {OP_R, 4'd11, 8'h06, 32'h0,        32'h0}         // R11 unaligned reads 0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq, bad_wr;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sec_rtc #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .bad_wr(bad_wr)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      report();
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic t);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 bad_wr after reset", {31'b0, bad_wr}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, rq;
      logic [7:0] a;
      logic [31:0] d, e;
      {op, rq, a, d, e} = VEC[i];
      if (op == OP_W) wr(a, d, 1'b0);
      else if (op == OP_T) tk();
      else begin
        rd(a, v);
        checks++;
        if (v !== e) begin
          fails++;
          $display("FAIL vector %0d (R%0d): act=%h exp=%h", i, rq, v, e);
        end
      end
    end

    // R11: rdata holds while rd_en is low
    @(negedge clk);
    chk("R11 rdata hold", rdata, 32'h0);
    // R2: wrap from all ones
    wr(8'h08, 32'hFFFFFFFF, 1'b0);
    tk();
    rd(8'h00, v); chk("R2 wrap", v, 32'h0);

    // R8: irq follows mask and raw on the same edge
    wr(8'h10, 32'h0, 1'b0);
    chk("R8 mask off drops irq", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h0, 1'b0);  // equals count 0: raw set
    chk("R8 raw set but masked", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h3, 1'b0);
    chk("R8 mask on raises irq", {31'b0, irq}, 32'h1);

    // R10: rejected writes pulse bad_wr for one cycle
    wr(8'h18, 32'h0, 1'b0);
    chk("R10 masked-status write flagged", {31'b0, bad_wr}, 32'h1);
    @(negedge clk);
    chk("R10 flag one cycle", {31'b0, bad_wr}, 32'h0);
    chk("R10 status untouched", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h0, 1'b0);
    chk("R10 raw-status write flagged", {31'b0, bad_wr}, 32'h1);
    chk("R10 raw write no clear", {31'b0, irq}, 32'h1);
    wr(8'h05, 32'h0, 1'b0);
    chk("R10 unaligned flagged", {31'b0, bad_wr}, 32'h1);
    wr(8'h40, 32'h0, 1'b0);
    chk("R10 out of window flagged", {31'b0, bad_wr}, 32'h1);
    wr(8'h0C, 32'h0, 1'b0);
    chk("R10 control write not flagged", {31'b0, bad_wr}, 32'h0);
    wr(8'h04, 32'h0, 1'b0);
    chk("R10 match write not flagged", {31'b0, bad_wr}, 32'h0);

    // R7: set wins over a same-cycle clear
    wr(8'h08, 32'h20, 1'b0);
    wr(8'h04, 32'h21, 1'b0);
    wr(8'h1C, 32'h0, 1'b0);
    chk("R7 clear drops irq", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'hDEADBEEF, 1'b1);
    chk("R7 set wins irq", {31'b0, irq}, 32'h1);
    rd(8'h14, v); chk("R7 set wins raw", v, 32'h1);
    wr(8'h1C, 32'h12345678, 1'b0);
    chk("R7 any data clears", {31'b0, irq}, 32'h0);

    // R3: load beats a same-cycle tick
    wr(8'h08, 32'h500, 1'b1);
    rd(8'h00, v); chk("R3 load over tick", v, 32'h500);
    // R5: no new set while count differs from match
    rd(8'h14, v); chk("R5 no spurious set", v, 32'h0);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq after mid reset", {31'b0, irq}, 32'h0);
    rd(8'h00, v); chk("R1 counter after mid reset", v, 32'h0);
    rd(8'h10, v); chk("R1 mask after mid reset", v, 32'h0);
    rd(8'h04, v); chk("R1 match after mid reset", v, 32'h0);

    report();
  end
endmodule